// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine with HI/LO Result Pair

This block performs integer multiplication and division for a 32-bit core. The results do not go to a general register file. They go to a pair of dedicated result registers: HI holds the upper word of a product or a remainder, and LO holds the lower word of a product or a quotient. A request carries a 6-bit function code and two operands. The function code selects signed or unsigned multiply, signed or unsigned divide, a read of HI or LO, or a write of HI or LO from the first operand.

Multiply uses a shift-and-add datapath and divide uses a restoring shift-and-subtract datapath. Both retire one bit per clock. Signed operations run on operand magnitudes, and the signs are fixed in a final cycle. A controller has three states: ST_IDLE, ST_RUN and ST_FINISH. Its transitions are:

- ST_IDLE to ST_RUN when a multiply or divide is accepted.
- ST_RUN to ST_FINISH on the last iteration.
- ST_FINISH to ST_IDLE after HI and LO are written.
- ST_RUN or ST_FINISH to ST_IDLE when a write to HI or LO arrives (abort).

`busy` is high in every state except ST_IDLE, so the pipeline can stall against it. A read that arrives while `busy` is high is held and answered when the operation finishes.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO read as zero, `busy` is low and `resp_valid` is low.
- R2: Function 0x18 (signed multiply) and 0x19 (unsigned multiply) place the low half of the double-width product in LO and the high half in HI.
- R3: Function 0x1a (signed divide) and 0x1b (unsigned divide) place the quotient in LO and the remainder in HI. Signed division rounds the quotient toward zero, and the remainder has the sign of the dividend.
- R4: An accepted multiply or divide holds `busy` high for DATA_W+1 cycles, beginning the cycle after the accepting edge. HI and LO are written at the edge where `busy` falls and stay unchanged before it.
- R5: A read of HI (0x10) or LO (0x12) while idle raises `resp_valid` for one cycle, with the register value on `resp_data`, in the cycle after the request.
- R6: A write of HI (0x11) or LO (0x13) loads `req_a` into that register and leaves the other register unchanged.
- R7: A read that arrives while busy produces no response until completion. It is then answered in the cycle after `busy` falls, with the new result.
- R8: A write of HI or LO while busy aborts the operation: `busy` is low in the next cycle, and the other register keeps its value from before the operation. A held read is answered at that same edge, with the register values as they stand after the write.
- R9: A multiply or divide request while busy is ignored. The running operation completes with its own result.
- R10: Division by zero completes normally. The remainder equals the dividend. The quotient is all ones, except for a signed divide of a negative dividend, where it is 1.
- R11: Function codes other than the eight listed change nothing and give no response.
- R12: A signed divide of the most negative value by -1 gives a quotient equal to the most negative value and a remainder of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_func | input | 6 | Function code of the request |
| req_a | input | DATA_W | First operand, or the value for a HI/LO write |
| req_b | input | DATA_W | Second operand |
| busy | output | 1 | An operation is in progress |
| resp_valid | output | 1 | One-cycle pulse marking a read response |
| resp_data | output | DATA_W | Value of HI or LO for the read |

## Verification
An iteration counter that is off by one changes the width of the `busy` window, and the data read back is then shifted or missing a bit. Either fault shows within DATA_W+1 cycles of a start. A corrupted sign flag or magnitude reaches the ports only when HI and LO are read after completion, so every operand pair of a 5-bit configuration is swept for all four arithmetic codes, and both halves are read back each time. A wrong held-read or abort state shows as a response that is missing, early or stale, in the cycle after completion or after the abort.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam logic [5:0] FN_RDHI = 6'h10;
    localparam logic [5:0] FN_WRHI = 6'h11;
    localparam logic [5:0] FN_RDLO = 6'h12;
    localparam logic [5:0] FN_WRLO = 6'h13;
    localparam logic [5:0] FN_MULS = 6'h18;
    localparam logic [5:0] FN_MULU = 6'h19;
    localparam logic [5:0] FN_DIVS = 6'h1a;
    localparam logic [5:0] FN_DIVU = 6'h1b;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MUL,
        CMD_DIV,
        CMD_RDHI,
        CMD_RDLO,
        CMD_WRHI,
        CMD_WRLO
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } state_e;

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
    import mdu_pkg::*;
(
    input  logic       valid,
    input  logic [5:0] func,
    output cmd_e       cmd,
    output logic       is_signed
);
    always_comb begin
        cmd       = CMD_NONE;
        is_signed = 1'b0;
        if (valid) begin
            unique case (func)
                FN_MULS: begin cmd = CMD_MUL;  is_signed = 1'b1; end
                FN_MULU: begin cmd = CMD_MUL;  end
                FN_DIVS: begin cmd = CMD_DIV;  is_signed = 1'b1; end
                FN_DIVU: begin cmd = CMD_DIV;  end
                FN_RDHI: begin cmd = CMD_RDHI; end
                FN_RDLO: begin cmd = CMD_RDLO; end
                FN_WRHI: begin cmd = CMD_WRHI; end
                FN_WRLO: begin cmd = CMD_WRLO; end
                default: begin cmd = CMD_NONE; end
            endcase
        end
    end
endmodule

// File: rtl/mdu_prep.sv
module mdu_prep #(
    parameter int DATA_W = 32
) (
    input  logic              is_signed,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] mag_a,
    output logic [DATA_W-1:0] mag_b,
    output logic              neg_a,
    output logic              neg_b
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        neg_a = is_signed & opa[MSB];
        neg_b = is_signed & opb[MSB];
        mag_a = neg_a ? (~opa + 1'b1) : opa;
        mag_b = neg_b ? (~opb + 1'b1) : opb;
    end
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              is_div,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] raw_hi,
    output logic [DATA_W-1:0] raw_lo,
    output logic              last
);
    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(DATA_W - 1);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] low_q;
    logic [DATA_W-1:0] opnd_q;
    logic [CW-1:0]     cnt_q;
    logic              div_q;

    logic [DATA_W:0]   mul_sum;
    logic [DATA_W:0]   shifted;
    logic [DATA_W:0]   trial;
    logic [DATA_W-1:0] acc_d;
    logic [DATA_W-1:0] low_d;

    always_comb begin
        mul_sum = {1'b0, acc_q} + {1'b0, (low_q[0] ? opnd_q : '0)};
        shifted = {acc_q, low_q[DATA_W-1]};
        trial   = shifted - {1'b0, opnd_q};
        if (div_q) begin
            if (!trial[DATA_W]) begin
                acc_d = trial[DATA_W-1:0];
                low_d = {low_q[DATA_W-2:0], 1'b1};
            end else begin
                acc_d = shifted[DATA_W-1:0];
                low_d = {low_q[DATA_W-2:0], 1'b0};
            end
        end else begin
            acc_d = mul_sum[DATA_W:1];
            low_d = {mul_sum[0], low_q[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            low_q  <= '0;
            opnd_q <= '0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (load) begin
            acc_q  <= '0;
            low_q  <= opa;
            opnd_q <= opb;
            cnt_q  <= '0;
            div_q  <= is_div;
        end else if (step) begin
            acc_q <= acc_d;
            low_q <= low_d;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    assign last   = (cnt_q == LAST_CNT);
    assign raw_hi = acc_q;
    assign raw_lo = low_q;

    // R4: the iteration counter never passes the final step
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R4: a load restarts the iteration from step zero with a clear accumulator
    a_r4_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0) && (acc_q == '0));
endmodule

// File: rtl/mdu_post.sv
module mdu_post #(
    parameter int DATA_W = 32
) (
    input  logic              is_div,
    input  logic              neg_res,
    input  logic              neg_rem,
    input  logic [DATA_W-1:0] raw_hi,
    input  logic [DATA_W-1:0] raw_lo,
    output logic [DATA_W-1:0] fix_hi,
    output logic [DATA_W-1:0] fix_lo
);
    localparam int PW = 2 * DATA_W;

    logic [PW-1:0] prod;

    always_comb begin
        prod = {raw_hi, raw_lo};
        if (neg_res) begin
            prod = ~prod + 1'b1;
        end
        if (is_div) begin
            fix_lo = neg_res ? (~raw_lo + 1'b1) : raw_lo;
            fix_hi = neg_rem ? (~raw_hi + 1'b1) : raw_hi;
        end else begin
            fix_lo = prod[DATA_W-1:0];
            fix_hi = prod[PW-1:DATA_W];
        end
    end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_func,
    input  logic [DATA_W-1:0] req_a,
    input  logic [DATA_W-1:0] req_b,
    output logic              busy,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);
    cmd_e              cmd;
    logic              is_signed;
    logic [DATA_W-1:0] mag_a, mag_b;
    logic              neg_a, neg_b;
    logic [DATA_W-1:0] raw_hi, raw_lo, fix_hi, fix_lo;
    logic              eng_last;

    state_e            st_q, st_d;
    logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic              is_div_q, neg_res_q, neg_rem_q;
    logic              pend_q, pend_hi_q, pend_d, pend_hi_d;
    logic              resp_valid_q, resp_valid_d;
    logic [DATA_W-1:0] resp_data_q, resp_data_d;

    logic start_ok, wr_cmd, rd_cmd, abort, step, serve, serve_hi;

    mdu_decode u_decode (
        .valid     (req_valid),
        .func      (req_func),
        .cmd       (cmd),
        .is_signed (is_signed)
    );

    mdu_prep #(.DATA_W(DATA_W)) u_prep (
        .is_signed (is_signed),
        .opa       (req_a),
        .opb       (req_b),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_a     (neg_a),
        .neg_b     (neg_b)
    );

    mdu_engine #(.DATA_W(DATA_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_ok),
        .step   (step),
        .is_div (cmd == CMD_DIV),
        .opa    (mag_a),
        .opb    (mag_b),
        .raw_hi (raw_hi),
        .raw_lo (raw_lo),
        .last   (eng_last)
    );

    mdu_post #(.DATA_W(DATA_W)) u_post (
        .is_div  (is_div_q),
        .neg_res (neg_res_q),
        .neg_rem (neg_rem_q),
        .raw_hi  (raw_hi),
        .raw_lo  (raw_lo),
        .fix_hi  (fix_hi),
        .fix_lo  (fix_lo)
    );

    // request classification
    always_comb begin
        wr_cmd   = (cmd == CMD_WRHI) || (cmd == CMD_WRLO);
        rd_cmd   = (cmd == CMD_RDHI) || (cmd == CMD_RDLO);
        start_ok = (st_q == ST_IDLE) && ((cmd == CMD_MUL) || (cmd == CMD_DIV));
        abort    = wr_cmd && (st_q != ST_IDLE);
        step     = (st_q == ST_RUN) && !abort;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = start_ok ? ST_RUN : ST_IDLE;
            ST_RUN:    st_d = abort ? ST_IDLE : (eng_last ? ST_FINISH : ST_RUN);
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // result registers, held read and response next values
    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (cmd == CMD_WRHI) begin
            hi_d = req_a;
        end else if (cmd == CMD_WRLO) begin
            lo_d = req_a;
        end else if (st_q == ST_FINISH) begin
            hi_d = fix_hi;
            lo_d = fix_lo;
        end

        serve    = (rd_cmd && (st_q != ST_RUN)) ||
                   (pend_q && (abort || (st_q == ST_FINISH)));
        serve_hi = rd_cmd ? (cmd == CMD_RDHI) : pend_hi_q;

        pend_d    = pend_q;
        pend_hi_d = pend_hi_q;
        if (rd_cmd && (st_q == ST_RUN)) begin
            pend_d    = 1'b1;
            pend_hi_d = (cmd == CMD_RDHI);
        end else if (serve || abort || (st_q == ST_FINISH)) begin
            pend_d = 1'b0;
        end

        resp_valid_d = serve;
        resp_data_d  = serve ? (serve_hi ? hi_d : lo_d) : resp_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q         <= '0;
            lo_q         <= '0;
            is_div_q     <= 1'b0;
            neg_res_q    <= 1'b0;
            neg_rem_q    <= 1'b0;
            pend_q       <= 1'b0;
            pend_hi_q    <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            hi_q         <= hi_d;
            lo_q         <= lo_d;
            pend_q       <= pend_d;
            pend_hi_q    <= pend_hi_d;
            resp_valid_q <= resp_valid_d;
            resp_data_q  <= resp_data_d;
            if (start_ok) begin
                is_div_q  <= (cmd == CMD_DIV);
                neg_res_q <= neg_a ^ neg_b;
                neg_rem_q <= neg_a;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (st_q != ST_IDLE);
        resp_valid = resp_valid_q;
        resp_data  = resp_data_q;
    end

    // R4: an accepted start raises busy on the next cycle
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy);

    // R4: HI and LO hold while iterating
    a_r4_hold_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !abort) |=> ($stable(hi_q) && $stable(lo_q)));

    // R7: no response while iterating
    a_r7_no_reply_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !abort) |=> !resp_valid);

    // R5: an idle read of HI answers on the next cycle
    a_r5_read_hi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cmd == CMD_RDHI) |=> (resp_valid && resp_data == $past(hi_q)));

    // R6: a LO write loads the first operand
    a_r6_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRLO) |=> (lo_q == $past(req_a)));

    // R6: a HI write loads the first operand
    a_r6_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRHI) |=> (hi_q == $past(req_a)));

    // R8: a write while busy leaves the block idle
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    // R11: an idle cycle without a known request changes nothing
    a_r11_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cmd == CMD_NONE) |=>
            ($stable(hi_q) && $stable(lo_q) && !busy && !resp_valid));
endmodule

// File: tb/mdu_hilo_test.sv
module mdu_hilo_test;
    localparam int W          = 5;
    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 1 << W;
    localparam int HALF       = FULL / 2;
    localparam int MASK       = FULL - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   req_func = '0;
    logic [W-1:0] req_a = '0;
    logic [W-1:0] req_b = '0;
    logic         busy;
    logic         resp_valid;
    logic [W-1:0] resp_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdu_hilo #(.DATA_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_func   (req_func),
        .req_a      (req_a),
        .req_b      (req_b),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] fn, input int a, input int b);
        @(negedge clk);
        req_valid = 1'b1;
        req_func  = fn;
        req_a     = W'(a);
        req_b     = W'(b);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input bit hi, output int v, output bit ok);
        issue(hi ? 6'h10 : 6'h12, 0, 0);
        ok = resp_valid;
        v  = int'(resp_data);
    endtask

    task automatic read_check(input bit hi, input int exp, input string tag);
        int  v;
        bit  ok;
        read_reg(hi, v, ok);
        check(ok && v == exp, tag, ok ? v : -1, exp);
    endtask

    function automatic void model(input logic [5:0] fn, input int a, input int b,
                                  output int eh, output int el);
        int     sa, sb, q, r;
        longint p;
        sa = (a >= HALF) ? a - FULL : a;
        sb = (b >= HALF) ? b - FULL : b;
        eh = 0;
        el = 0;
        case (fn)
            6'h18: begin
                p  = longint'(sa) * longint'(sb);
                el = int'(p & longint'(MASK));
                eh = int'((p >>> W) & longint'(MASK));
            end
            6'h19: begin
                p  = longint'(a) * longint'(b);
                el = int'(p & longint'(MASK));
                eh = int'((p >>> W) & longint'(MASK));
            end
            6'h1a: begin
                if (sb == 0) begin
                    r = sa;
                    q = (sa < 0) ? 1 : -1;
                end else begin
                    q = sa / sb;
                    r = sa % sb;
                end
                el = q & MASK;
                eh = r & MASK;
            end
            default: begin
                if (b == 0) begin
                    q = -1;
                    r = a;
                end else begin
                    q = a / b;
                    r = a % b;
                end
                el = q & MASK;
                eh = r & MASK;
            end
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int    n, eh, el, v;
        bit    ok;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 busy", int'(busy), 0);
        check(!resp_valid, "R1 resp_valid", int'(resp_valid), 0);
        read_check(1'b1, 0, "R1 hi");
        read_check(1'b0, 0, "R1 lo");

        // R6 and R5: writes then idle reads
        issue(6'h11, 21, 0);
        issue(6'h13, 6, 0);
        read_check(1'b1, 21, "R5 R6 hi");
        read_check(1'b0, 6, "R5 R6 lo");
        issue(6'h13, 9, 0);
        read_check(1'b1, 21, "R6 other kept");

        // R11: unknown codes
        issue(6'h20, 31, 31);
        check(!busy && !resp_valid, "R11 no reaction", int'(busy) + int'(resp_valid), 0);
        issue(6'h1c, 31, 31);
        check(!busy && !resp_valid, "R11 no reaction 1c", int'(busy) + int'(resp_valid), 0);
        read_check(1'b1, 21, "R11 hi");
        read_check(1'b0, 9, "R11 lo");

        // R7: held read answered after completion
        issue(6'h1b, 29, 4);
        issue(6'h10, 0, 0);
        check(busy && !resp_valid, "R7 held", int'(resp_valid), 0);
        while (busy) begin
            check(!resp_valid, "R7 early reply", int'(resp_valid), 0);
            @(negedge clk);
        end
        check(resp_valid && int'(resp_data) == 1, "R7 reply", int'(resp_data), 1);
        read_check(1'b0, 7, "R7 lo");

        // R8: write while busy aborts and answers the held read
        issue(6'h11, 10, 0);
        issue(6'h13, 5, 0);
        issue(6'h19, 3, 7);
        issue(6'h12, 0, 0);
        check(!resp_valid, "R8 held", int'(resp_valid), 0);
        issue(6'h11, 17, 0);
        check(!busy, "R8 busy dropped", int'(busy), 0);
        check(resp_valid && int'(resp_data) == 5, "R8 held read", int'(resp_data), 5);
        read_check(1'b1, 17, "R8 hi");
        read_check(1'b0, 5, "R8 lo kept");

        // R9: start while busy ignored
        issue(6'h19, 3, 4);
        issue(6'h1b, 31, 1);
        wait_idle(n);
        read_check(1'b1, 0, "R9 hi");
        read_check(1'b0, 12, "R9 lo");

        // exhaustive sweep of all four arithmetic codes (R2 R3 R4 R10 R12)
        for (int f = 0; f < 4; f++) begin
            for (int a = 0; a < FULL; a++) begin
                for (int b = 0; b < FULL; b++) begin
                    logic [5:0] fn;
                    fn = 6'h18 + 6'(f);
                    model(fn, a, b, eh, el);
                    if (f >= 2 && b == 0) tag = "R10";
                    else if (f == 2 && a == HALF && b == MASK) tag = "R12";
                    else if (f < 2) tag = "R2";
                    else tag = "R3";
                    issue(fn, a, b);
                    wait_idle(n);
                    check(n == W + 1, "R4 busy window", n, W + 1);
                    read_reg(1'b1, v, ok);
                    check(ok && v == eh, {tag, " hi"}, v, eh);
                    read_reg(1'b0, v, ok);
                    check(ok && v == el, {tag, " lo"}, v, el);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule